// File: doc/BRIEF.md
# Endpoint Stall Control Register

This block is an 8-bit control register that a CPU writes inside a USB device controller. It keeps one stall flag for each of endpoints 0 to 3. It also keeps one auto-clear enable that applies to every endpoint. Each flag drives an output line that tells the protocol engine to answer host accesses to that endpoint with a STALL handshake.

The flags can also clear without software action. The endpoint 0 flag drops when the controller decodes a setup command. When auto-clear is enabled, any endpoint's flag drops once the engine reports that it has sent a STALL handshake on that endpoint. A setup-received status level comes from the interrupt flag logic. While that level is high, software cannot set the endpoint 0 flag, so a late write cannot stall a control transfer that has just begun.

Top module: `ep_stall_ctl`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and `stall_ep` is 4'b0000.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data[3:0]` into the stall flags of endpoints 3..0 (bit n is endpoint n) and `wr_data[4]` into the auto-clear enable. `rd_data` returns the flags in bits 3..0 and the enable in bit 4. Bits 7..5 always read 0, whatever was written to them.
- R3: `stall_ep[n]` equals the stall flag of endpoint n at all times. The output changes one cycle after the event that changes the flag.
- R4: A `setup_decoded` pulse clears the endpoint 0 stall flag at the next edge. The other bits are unchanged.
- R5: While `setup_pending` is high, a write with `wr_data[0]`=1 leaves the endpoint 0 flag unchanged. The other bits of that write still take effect. A write with `wr_data[0]`=0 still clears the flag.
- R6: When the auto-clear enable is 1, a `hs_stall_sent` pulse clears only the flag of the endpoint named by `hs_ep`, at the next edge.
- R7: When the auto-clear enable is 0, `hs_stall_sent` has no effect on any flag.
- R8: If a hardware clear event and a write of 1 to the same flag fall in the same cycle, the flag ends up 0.
- R9: Auto-clear uses the enable value held before the current edge. A write to the enable in the same cycle as a handshake pulse takes effect only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| setup_pending | input | 1 | Setup-received status level |
| setup_decoded | input | 1 | One-cycle pulse: setup command decoded |
| hs_stall_sent | input | 1 | One-cycle pulse: STALL handshake sent |
| hs_ep | input | 2 | Endpoint number for `hs_stall_sent` |
| stall_ep | output | 4 | Per-endpoint stall request to the protocol engine |

## Verification
All state in this block is visible on `rd_data` and `stall_ep`. A wrong flag or enable therefore shows at the ports one cycle after the edge that stored it. The bench compares both outputs with a reference model after every edge. A missed clear, a blocked write leaking through, or a clear that hits the wrong endpoint is reported on the cycle it happens. An error in the enable shows up indirectly as well: the next handshake pulse clears a flag wrongly or fails to clear it.

// File: rtl/ep_stall_ctl.sv
module ep_stall_ctl #(
  parameter int EP_CNT = 4,
  localparam int EPW = $clog2(EP_CNT),
  localparam int ACE_BIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  output logic [7:0]     rd_data,
  input  logic           setup_pending,
  input  logic           setup_decoded,
  input  logic           hs_stall_sent,
  input  logic [EPW-1:0] hs_ep,
  output logic [EP_CNT-1:0] stall_ep
);

  logic [EP_CNT-1:0] flag;
  logic [EP_CNT-1:0] hw_clr;
  logic [EP_CNT-1:0] wr_ok;
  logic              acen;

  for (genvar i = 0; i < EP_CNT; i++) begin : g_ep
    if (i == 0) begin : g_ctl
      assign hw_clr[i] = setup_decoded || (acen && hs_stall_sent && hs_ep == EPW'(i));
      assign wr_ok[i]  = wr_en && !(setup_pending && wr_data[i]);
    end else begin : g_dat
      assign hw_clr[i] = acen && hs_stall_sent && hs_ep == EPW'(i);
      assign wr_ok[i]  = wr_en;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         flag[i] <= 1'b0;
      else if (hw_clr[i]) flag[i] <= 1'b0;
      else if (wr_ok[i])  flag[i] <= wr_data[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     acen <= 1'b0;
    else if (wr_en) acen <= wr_data[ACE_BIT];

  always_comb begin
    rd_data = '0;
    rd_data[EP_CNT-1:0] = flag;
    rd_data[ACE_BIT] = acen;
  end

  assign stall_ep = flag;

endmodule

module ep_stall_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       setup_pending,
  input logic       setup_decoded,
  input logic       hs_stall_sent,
  input logic [1:0] hs_ep,
  input logic [3:0] stall_ep
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000); // R2
  AST_STALL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ep == rd_data[3:0]); // R3
  AST_SETUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    setup_decoded |=> !stall_ep[0]); // R4
  AST_EP0_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_pending && wr_en && wr_data[0] && !stall_ep[0]) |=> !stall_ep[0]); // R5
  AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_stall_sent && rd_data[4]) |=> !stall_ep[$past(hs_ep)]); // R6
  AST_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_stall_sent && !rd_data[4] && !wr_en && !setup_decoded) |=> $stable(stall_ep)); // R7
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_decoded && wr_en && wr_data[0]) |=> !stall_ep[0]); // R8
endmodule

bind ep_stall_ctl ep_stall_ctl_chk u_chk (.*);

// File: tb/ep_stall_ctl_bench.sv
module ep_stall_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       setup_pending = 1'b0;
  logic       setup_decoded = 1'b0;
  logic       hs_stall_sent = 1'b0;
  logic [1:0] hs_ep = '0;
  logic [3:0] stall_ep;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] exp_st = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ep_stall_ctl u_ep_stall_ctl (.*);

  function automatic logic [4:0] model(input logic [4:0] cur, input logic we, input logic [7:0] d,
                                       input logic sp, input logic sd, input logic hs, input logic [1:0] e);
    logic [4:0] nx;
    nx = cur;
    if (we) begin
      nx[4:1] = d[4:1];
      if (!(sp && d[0])) nx[0] = d[0];
    end
    if (sd) nx[0] = 1'b0;
    if (cur[4] && hs) nx[e] = 1'b0;
    return nx;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (rd_data !== {3'b000, exp_st}) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, {3'b000, exp_st});
    end
    n_cmp++;
    if (stall_ep !== exp_st[3:0]) begin
      n_bad++;
      $display("FAIL %s stall_ep actual=%b expected=%b", tag, stall_ep, exp_st[3:0]);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic sp, input logic sd,
                      input logic hs, input logic [1:0] e, input string tag);
    wr_en = we; wr_data = d; setup_pending = sp; setup_decoded = sd; hs_stall_sent = hs; hs_ep = e;
    exp_st = model(exp_st, we, d, sp, sd, hs, e);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; setup_decoded = 1'b0; hs_stall_sent = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(1, 8'h1F, 0, 0, 0, 0, "R2");
    step(1, 8'hFF, 0, 0, 0, 0, "R2");
    step(1, 8'h0E, 0, 0, 0, 0, "R3");
    step(0, 8'h00, 0, 0, 1, 2'd1, "R7");
    step(1, 8'h1E, 0, 0, 0, 0, "R2");
    step(0, 8'h00, 0, 0, 1, 2'd2, "R6");
    step(0, 8'h00, 0, 0, 1, 2'd0, "R6");
    step(1, 8'h1F, 1, 0, 0, 0, "R5");
    step(1, 8'h1F, 0, 0, 0, 0, "R2");
    step(1, 8'h1E, 1, 0, 0, 0, "R5");
    step(1, 8'h1F, 0, 0, 0, 0, "R2");
    step(0, 8'h00, 0, 1, 0, 0, "R4");
    step(1, 8'h1F, 0, 1, 0, 0, "R8");
    step(1, 8'h1F, 0, 0, 1, 2'd3, "R8");
    step(1, 8'h0F, 0, 0, 1, 2'd1, "R9");
    step(1, 8'h1F, 0, 0, 1, 2'd2, "R9");

    void'($urandom(32'd20250611));
    for (int k = 0; k < 400; k++) begin
      logic we, sp, sd, hs;
      we = ($urandom % 10) < 4;
      sp = ($urandom % 10) < 3;
      sd = ($urandom % 100) < 15;
      hs = ($urandom % 10) < 3;
      step(we, 8'($urandom), sp, sd, hs, 2'($urandom), "R3 random");
    end

    rst_n = 1'b0;
    exp_st = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule